// File: doc/BRIEF.md
# Serial device identifier with CRC-8

This block holds the 64-bit registration identifier of a slave on a single-wire bus and handles both directions of that identifier at the bit level. The family code (8 bits) and the serial number (48 bits) are fixed by parameters. In transmit, the block forms the identifier from those fields plus a check byte and offers it one bit at a time. The surrounding bus logic reads `tx_bit` and pulses `bit_req` once that bit has gone out on the wire. In receive, the bus logic presents each incoming bit on `rx_bit` together with a `bit_req` pulse, and the block reports whether the 64 bits it collected form a consistent identifier.

A single bit-serial CRC register with XOR feedback serves both directions. The generator polynomial is x^8 + x^5 + x^4 + 1, and the register shifts right. A controller with three states decides what the register is fed:
- ST_IDLE: waiting; no frame is active.
- ST_SEND: transmitting the identifier.
- ST_RECV: checking a received identifier.

The transitions are:
- start_tx, taken from any state, goes to ST_SEND.
- start_rx, taken from any state when start_tx is low, goes to ST_RECV.
- last_send goes from ST_SEND to ST_IDLE on the `bit_req` that consumes bit 63.
- last_recv goes from ST_RECV to ST_IDLE on the same condition.

Bus timing, reset and presence signalling, and search arbitration belong to the surrounding bus logic.

Top module: `romid_core`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `tx_bit`, `busy`, `done` and `crc_error` are all 0.
- R2: In ST_SEND, `tx_bit` shows frame bit i, where i is the number of `bit_req` pulses taken since the frame started. Bits 0..7 are FAMILY bit 0 to bit 7, and bits 8..55 are SERIAL bit 0 to bit 47, so each field goes least significant bit first.
- R3: Frame bits 56..63 are the check byte, sent least significant bit first. The check byte is computed over frame bits 0..55 in order, starting from 0x00. For each bit: fb = bit XOR crc[0], then crc = crc >> 1, and if fb is 1 then crc ^= 0x8C (fb goes into bit 7 and into bits 3 and 2).
- R4: The `bit_req` that consumes bit 63 returns the block to ST_IDLE. `done` is 1 for exactly one cycle, the cycle after that request.
- R5: `start_tx` or `start_rx` in any state clears the bit index and the CRC register and enters ST_SEND or ST_RECV. When both are high, `start_tx` wins. A `bit_req` in the same cycle as a start is not counted.
- R6: A `bit_req` in ST_IDLE is ignored: `busy` stays 0, no `done` follows, and `tx_bit` stays 0.
- R7: In ST_RECV, `rx_bit` is sampled on each `bit_req`, and all 64 bits pass through the CRC register. `crc_error` is 1 together with `done` when the final remainder is not zero. For a consistent identifier it stays 0.
- R8: Any received identifier that differs from a valid one in exactly one bit position, anywhere among bits 0..63, gives `crc_error` = 1.
- R9: `tx_bit` is 0 whenever the state is not ST_SEND, which includes ST_RECV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_tx | input | 1 | Begin sending the identifier from bit 0 |
| start_rx | input | 1 | Begin checking a received identifier |
| bit_req | input | 1 | One-cycle strobe that consumes the current bit |
| rx_bit | input | 1 | Received bit, sampled with `bit_req` in ST_RECV |
| tx_bit | output | 1 | Current identifier bit while sending |
| busy | output | 1 | High in ST_SEND or ST_RECV |
| done | output | 1 | One-cycle pulse after bit 63 is consumed |
| crc_error | output | 1 | One-cycle pulse alongside `done` for a bad received identifier |

## Verification
Several properties are checked on every cycle by the assertions:
- the bit index moves by exactly one per accepted request and wraps after bit 63;
- the CRC register clears on a start and holds while the check byte is being sent;
- a request in ST_IDLE leaves the state unchanged, and `start_tx` takes priority;
- `done` never lasts two cycles, and `crc_error` never appears without it.

Only the bench's scenarios can show the values themselves. These are the check byte for several family and serial pairs, the exact bit order of the frame, and detection of a flipped bit at each of the 64 positions. The bench also covers restarts in the middle of a frame and requests with idle gaps between them.

// File: rtl/romid_pkg.sv
package romid_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2
    } romid_state_e;

    typedef struct packed {
        logic restart;   // clear index and CRC
        logic step;      // a bit is consumed this cycle
        logic crc_en;    // CRC register absorbs a bit
        logic use_rx;    // CRC input comes from rx_bit
    } romid_ctl_t;

endpackage

// File: rtl/romid_crc.sv
module romid_crc #(
    parameter int unsigned          CRC_W    = 8,
    parameter logic [CRC_W-1:0]     TAP_MASK = 8'h8C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_d
);

    logic fb;
    assign fb = din ^ crc_q[0];

    // Right-shifting register; feedback enters at the tap positions.
    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
        if (i == CRC_W - 1) begin : g_top
            assign crc_d[i] = fb & TAP_MASK[i];
        end else begin : g_mid
            assign crc_d[i] = crc_q[i+1] ^ (fb & TAP_MASK[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= crc_d;
        end
    end

    AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0)); // R5

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc_q)); // R3

endmodule

// File: rtl/romid_seq.sv
module romid_seq #(
    parameter int unsigned ID_W  = 64,
    localparam int unsigned IDX_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    assign last = (idx == IDX_W'(ID_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !last) |=> (idx == $past(idx) + 1'b1)); // R2

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && last) |=> (idx == '0)); // R4

endmodule

// File: rtl/romid_bitsel.sv
module romid_bitsel #(
    parameter int unsigned       FAM_W  = 8,
    parameter int unsigned       SER_W  = 48,
    parameter int unsigned       CRC_W  = 8,
    parameter logic [FAM_W-1:0]  FAMILY = '0,
    parameter logic [SER_W-1:0]  SERIAL = '0,
    localparam int unsigned      ID_W   = FAM_W + SER_W + CRC_W,
    localparam int unsigned      PAY_W  = FAM_W + SER_W,
    localparam int unsigned      IDX_W  = $clog2(ID_W)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CRC_W-1:0] crc,
    output logic             sel_bit,
    output logic             in_payload
);

    logic [ID_W-1:0] frame;

    // Transmission order: family, serial, check byte, each LSB first.
    assign frame      = {crc, SERIAL, FAMILY};
    assign sel_bit    = frame[idx];
    assign in_payload = (32'(idx) < PAY_W);

endmodule

// File: rtl/romid_ctrl.sv
module romid_ctrl
    import romid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_tx,
    input  logic       start_rx,
    input  logic       bit_req,
    input  logic       last,
    input  logic       in_payload,
    input  logic       crc_fail_nxt,
    output romid_ctl_t ctl,
    output logic       busy,
    output logic       sending,
    output logic       done,
    output logic       crc_error
);

    romid_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (start_tx) begin
            state_d = ST_SEND;
        end else if (start_rx) begin
            state_d = ST_RECV;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SEND: if (bit_req && last) state_d = ST_IDLE;
                ST_RECV: if (bit_req && last) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ctl.restart = start_tx | start_rx;
        ctl.step    = !ctl.restart && bit_req && (state_q != ST_IDLE);
        ctl.use_rx  = (state_q == ST_RECV);
        ctl.crc_en  = ctl.step && (ctl.use_rx || in_payload);
        busy        = (state_q != ST_IDLE);
        sending     = (state_q == ST_SEND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            crc_error <= 1'b0;
        end else begin
            done      <= ctl.step && last;
            crc_error <= ctl.step && last && ctl.use_rx && crc_fail_nxt;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE || $past(start_tx || start_rx))); // R4

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> done); // R7

    AST_IDLE_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && bit_req && !start_tx && !start_rx) |=> (state_q == ST_IDLE)); // R6

    AST_TX_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        start_tx |=> (state_q == ST_SEND)); // R5

endmodule

// File: rtl/romid_core.sv
module romid_core
    import romid_pkg::*;
#(
    parameter int unsigned      FAM_W    = 8,
    parameter int unsigned      SER_W    = 48,
    parameter int unsigned      CRC_W    = 8,
    parameter logic [CRC_W-1:0] TAP_MASK = 8'h8C,
    parameter logic [FAM_W-1:0] FAMILY   = 8'h2D,
    parameter logic [SER_W-1:0] SERIAL   = 48'h0000_1234_ABCD,
    localparam int unsigned     ID_W     = FAM_W + SER_W + CRC_W,
    localparam int unsigned     IDX_W    = $clog2(ID_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_tx,
    input  logic start_rx,
    input  logic bit_req,
    input  logic rx_bit,
    output logic tx_bit,
    output logic busy,
    output logic done,
    output logic crc_error
);

    romid_ctl_t       ctl;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             sel_bit;
    logic             in_payload;
    logic             sending;
    logic             crc_din;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_d;

    romid_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_tx     (start_tx),
        .start_rx     (start_rx),
        .bit_req      (bit_req),
        .last         (last),
        .in_payload   (in_payload),
        .crc_fail_nxt (|crc_d),
        .ctl          (ctl),
        .busy         (busy),
        .sending      (sending),
        .done         (done),
        .crc_error    (crc_error)
    );

    romid_seq #(.ID_W(ID_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.restart),
        .adv   (ctl.step),
        .idx   (idx),
        .last  (last)
    );

    romid_bitsel #(
        .FAM_W  (FAM_W),
        .SER_W  (SER_W),
        .CRC_W  (CRC_W),
        .FAMILY (FAMILY),
        .SERIAL (SERIAL)
    ) u_sel (
        .idx        (idx),
        .crc        (crc_q),
        .sel_bit    (sel_bit),
        .in_payload (in_payload)
    );

    assign crc_din = ctl.use_rx ? rx_bit : sel_bit;

    romid_crc #(.CRC_W(CRC_W), .TAP_MASK(TAP_MASK)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctl.restart),
        .en    (ctl.crc_en),
        .din   (crc_din),
        .crc_q (crc_q),
        .crc_d (crc_d)
    );

    assign tx_bit = sending & sel_bit;

    AST_CRC_FROZEN_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !in_payload && !start_tx && !start_rx) |=> $stable(crc_q)); // R3

endmodule

// File: tb/romid_core_tb.sv
`timescale 1ns/1ps
module romid_core_tb_top;

    localparam int NI = 4;
    localparam logic [7:0]  FAMS [NI] = '{8'h2D, 8'h01, 8'hA5, 8'h00};
    localparam logic [47:0] SERS [NI] = '{48'h0000_1234_ABCD, 48'hFFFF_FFFF_FFFF,
                                          48'h5A3C_9E01_7720, 48'h0000_0000_0001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_tx = 1'b0, start_rx = 1'b0, bit_req = 1'b0;
    logic rx_bit_r [NI];
    logic tx_bit_w [NI], busy_w [NI], done_w [NI], err_w [NI];

    always #2 clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : g_dut
        romid_core #(.FAMILY(FAMS[g]), .SERIAL(SERS[g])) dut_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_tx  (start_tx),
            .start_rx  (start_rx),
            .bit_req   (bit_req),
            .rx_bit    (rx_bit_r[g]),
            .tx_bit    (tx_bit_w[g]),
            .busy      (busy_w[g]),
            .done      (done_w[g]),
            .crc_error (err_w[g])
        );
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural model of the check byte (reflected form, init 0).
    function automatic logic [7:0] ref_crc_bit(logic [7:0] c, logic b);
        logic [7:0] t;
        t = c ^ {7'b0, b};
        if (t[0]) return (t >> 1) ^ 8'h8C;
        return t >> 1;
    endfunction

    function automatic logic [63:0] build_id(logic [7:0] fam, logic [47:0] ser);
        logic [55:0] body;
        logic [7:0]  c;
        body = {ser, fam};
        c = 8'h00;
        for (int i = 0; i < 56; i++) c = ref_crc_bit(c, body[i]);
        return {c, body};
    endfunction

    logic [63:0] idw [NI];
    initial for (int k = 0; k < NI; k++) idw[k] = build_id(FAMS[k], SERS[k]);

    // Cycle model: 0 idle, 1 send, 2 receive
    int          m_state;
    int          m_idx;
    logic        m_done;
    logic        m_err  [NI];
    logic [7:0]  m_rcrc [NI];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_idx <= 0; m_done <= 1'b0;
            for (int k = 0; k < NI; k++) begin m_err[k] <= 1'b0; m_rcrc[k] <= 8'h00; end
        end else begin
            m_done <= 1'b0;
            for (int k = 0; k < NI; k++) m_err[k] <= 1'b0;
            if (start_tx || start_rx) begin
                m_state <= start_tx ? 1 : 2;
                m_idx   <= 0;
                for (int k = 0; k < NI; k++) m_rcrc[k] <= 8'h00;
            end else if (bit_req && m_state != 0) begin
                if (m_state == 2)
                    for (int k = 0; k < NI; k++) m_rcrc[k] <= ref_crc_bit(m_rcrc[k], rx_bit_r[k]);
                if (m_idx == 63) begin
                    m_state <= 0; m_idx <= 0; m_done <= 1'b1;
                    for (int k = 0; k < NI; k++)
                        m_err[k] <= (m_state == 2) && (ref_crc_bit(m_rcrc[k], rx_bit_r[k]) != 8'h00);
                end else begin
                    m_idx <= m_idx + 1;
                end
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        for (int k = 0; k < NI; k++) begin
            logic exp_tx;
            string tg;
            exp_tx = (m_state == 1) ? idw[k][m_idx] : 1'b0;
            tg = (m_state != 1) ? "R9" : ((m_idx < 56) ? "R2" : "R3");
            chk(tx_bit_w[k] === exp_tx, tg, "tx_bit", int'(tx_bit_w[k]), int'(exp_tx));
            chk(busy_w[k] === (m_state != 0), "R5", "busy", int'(busy_w[k]), int'(m_state != 0));
            chk(done_w[k] === m_done, "R4", "done", int'(done_w[k]), int'(m_done));
            chk(err_w[k] === m_err[k], "R7", "crc_error", int'(err_w[k]), int'(m_err[k]));
        end
    end

    logic [63:0] cap [NI];

    task automatic pulse_start(input logic tx, input logic rx);
        @(negedge clk); start_tx = tx; start_rx = rx;
        @(negedge clk); start_tx = 1'b0; start_rx = 1'b0;
    endtask

    // Consume n bits from index 0; flip >= 0 corrupts that received bit.
    task automatic clock_bits(input int n, input int gap, input int flip, input bit rx_mode);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < NI; k++) begin
                cap[k][i]   = tx_bit_w[k];
                rx_bit_r[k] = idw[k][i] ^ (i == flip);
            end
            bit_req = 1'b1;
            @(negedge clk);
            bit_req = 1'b0;
            if (i == 63) begin
                for (int k = 0; k < NI; k++) begin
                    chk(done_w[k] === 1'b1, "R4", "done after bit 63", int'(done_w[k]), 1);
                    if (rx_mode) begin
                        if (flip >= 0)
                            chk(err_w[k] === 1'b1, "R8", "flipped bit detected", int'(err_w[k]), 1);
                        else
                            chk(err_w[k] === 1'b0, "R7", "clean frame accepted", int'(err_w[k]), 0);
                    end
                end
            end
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic run_tx(input int gap);
        pulse_start(1'b1, 1'b0);
        clock_bits(64, gap, -1, 1'b0);
        for (int k = 0; k < NI; k++) begin
            chk(cap[k][55:0] === idw[k][55:0], "R2", "payload bits",
                int'(cap[k][31:0] ^ idw[k][31:0]), 0);
            chk(cap[k][63:56] === idw[k][63:56], "R3", "check byte",
                int'(cap[k][63:56]), int'(idw[k][63:56]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NI; k++) rx_bit_r[k] = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < NI; k++)
            chk(!tx_bit_w[k] && !busy_w[k] && !done_w[k] && !err_w[k], "R1", "outputs in reset",
                int'({tx_bit_w[k], busy_w[k], done_w[k], err_w[k]}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NI; k++)
            chk(!tx_bit_w[k] && !busy_w[k] && !done_w[k] && !err_w[k], "R1", "outputs after reset",
                int'({tx_bit_w[k], busy_w[k], done_w[k], err_w[k]}), 0);

        // R6: requests while idle
        for (int i = 0; i < 5; i++) begin
            bit_req = 1'b1; @(negedge clk); bit_req = 1'b0; @(negedge clk);
            for (int k = 0; k < NI; k++)
                chk(!busy_w[k] && !done_w[k] && !tx_bit_w[k], "R6", "idle request ignored",
                    int'({busy_w[k], done_w[k], tx_bit_w[k]}), 0);
        end

        run_tx(0);
        run_tx(2);

        // R5: restart mid-frame, and both starts together
        pulse_start(1'b1, 1'b0);
        clock_bits(20, 0, -1, 1'b0);
        pulse_start(1'b1, 1'b1);
        for (int k = 0; k < NI; k++)
            chk(busy_w[k] && tx_bit_w[k] === idw[k][0], "R5", "send wins, bit 0 again",
                int'(tx_bit_w[k]), int'(idw[k][0]));
        clock_bits(64, 0, -1, 1'b0);
        for (int k = 0; k < NI; k++)
            chk(cap[k] === idw[k], "R5", "full frame after restart", int'(cap[k][63:56]), int'(idw[k][63:56]));

        // R7: clean receive, also after a receive restart
        pulse_start(1'b0, 1'b1);
        clock_bits(64, 1, -1, 1'b1);
        pulse_start(1'b0, 1'b1);
        clock_bits(30, 0, 3, 1'b1);
        pulse_start(1'b0, 1'b1);
        clock_bits(64, 0, -1, 1'b1);

        // R8: single flipped bit at every position
        for (int p = 0; p < 64; p++) begin
            pulse_start(1'b0, 1'b1);
            clock_bits(64, 0, p, 1'b1);
        end

        // R9: tx_bit stays low while receiving (checked per cycle), then a final send
        run_tx(1);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule